// File: doc/BRIEF.md
# Tile Gradient Segmenter

The segmenter takes one frame of 8-bit grayscale pixels in raster order and labels every 8x8 tile of the image as foreground (kept) or background (removed). At each pixel it forms a horizontal and a vertical gradient with a 5x5 separable Sobel-type kernel. It adds the absolute values of both components over the 64 pixels of each tile. That sum stands in for the gradient magnitude and is compared with a threshold.

A frame opens with a one-cycle `frame_start` pulse, which also captures the threshold. Pixels then flow in over a valid/ready handshake. Four line memories of the image width feed the 5x5 window. One accumulator per tile column gathers a whole tile row. Once the rows that a tile row needs have arrived, the unit emits that row's decisions left to right on consecutive cycles, each tagged with its tile row and tile column. Input is stalled while the decisions go out.

Top module: `grad_tile_seg`

## Requirements
- R1: `pix_ready` is high only while a frame is open and no decision is pending or being emitted. A pixel is consumed at a rising edge where `pix_valid` and `pix_ready` are both high, and idle cycles between pixels have no effect on the results.
- R2: Let v=(1,4,6,4,1) and d=(-1,-2,0,2,1). For window row i (0 = top) and window column j (0 = left) around the centre pixel, gX = sum of v[i]*d[j]*p[i][j] and gY = sum of d[i]*v[j]*p[i][j].
- R3: A pixel closer than 2 pixels to any image edge contributes a gradient of zero.
- R4: The tile metric is the exact sum of |gX|+|gY| over the tile's 64 pixels. It is held in 21 bits and never wraps or saturates.
- R5: `dec_keep` is 1 (foreground) when the metric is greater than or equal to the threshold and 0 (background) otherwise.
- R6: The threshold is taken from `thr_in` in the cycle of `frame_start`. Changes to `thr_in` during the frame have no effect.
- R7: Each tile gets exactly one decision. The decisions of tile row t appear on consecutive cycles, tile column 0 first, with `dec_row`=t and `dec_col` equal to the tile column. Tile rows come out in increasing order.
- R8: `frame_start` clears all accumulators and counters, and any partly received frame is discarded.
- R9: After reset, and after the last pixel of a frame, `pix_ready` stays low until the next `frame_start`. After reset `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame and captures the threshold |
| thr_in | input | 21 | Segmentation threshold |
| pix_valid | input | 1 | Pixel available |
| pix_ready | output | 1 | Unit accepts a pixel |
| pix_data | input | 8 | Grayscale pixel |
| dec_valid | output | 1 | Tile decision present |
| dec_keep | output | 1 | 1 keep (foreground), 0 remove (background) |
| dec_row | output | max(1,clog2(IMG_H/8)) | Tile row index |
| dec_col | output | max(1,clog2(IMG_W/8)) | Tile column index |

## Verification
The hardest case to reach is a tile whose metric lands exactly on the threshold. The metric only exists deep inside a two-row-lagged 5x5 datapath. The bench computes every tile's metric itself from the kernel and border rules, then opens frames with the threshold set to one tile's exact metric and to that metric plus one. Aborting a frame halfway and holding `pix_valid` high through emission and after the last pixel drive the handshake into its stall and closed states.

// File: rtl/grad_tile_seg.sv
module grad_tile_seg #(
  parameter int IMG_W = 256,
  parameter int IMG_H = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic [20:0]          thr_in,
  input  logic                 pix_valid,
  output logic                 pix_ready,
  input  logic [7:0]           pix_data,
  output logic                 dec_valid,
  output logic                 dec_keep,
  output logic [((IMG_H/8)>1 ? $clog2(IMG_H/8) : 1)-1:0] dec_row,
  output logic [((IMG_W/8)>1 ? $clog2(IMG_W/8) : 1)-1:0] dec_col
);
  localparam int NTC  = IMG_W / 8;
  localparam int NTR  = IMG_H / 8;
  localparam int CW   = $clog2(IMG_W);
  localparam int RW   = $clog2(IMG_H);
  localparam int TCW  = NTC > 1 ? $clog2(NTC) : 1;
  localparam int TRW  = NTR > 1 ? $clog2(NTR) : 1;
  localparam int MAXM = 2 * 48 * 255;
  localparam int AW   = $clog2(64 * MAXM + 1);

  logic [7:0]     lb  [0:3][0:IMG_W-1];
  logic [7:0]     win [0:4][0:4];
  logic [AW-1:0]  acc [0:NTC-1];
  logic [AW-1:0]  thr_q;
  logic           active, pend, emitting, g_vld;
  logic [CW-1:0]  col_q;
  logic [RW-1:0]  row_q;
  logic [TRW-1:0] pend_row, e_row;
  logic [TCW-1:0] e_col, g_tc;

  wire take     = pix_valid && pix_ready;
  wire last_col = col_q == CW'(IMG_W - 1);
  wire last_row = row_q == RW'(IMG_H - 1);
  wire trig     = take && last_col && (last_row || (int'(row_q) >= 9 && row_q[2:0] == 3'd1));
  wire gv       = take && int'(row_q) >= 4 && int'(col_q) >= 4;
  wire [TRW-1:0] trig_row = last_row ? TRW'(NTR - 1) : TRW'((row_q >> 3) - RW'(1));
  wire [TCW-1:0] ctr_tc   = TCW'((col_q - CW'(2)) >> 3);

  assign pix_ready = active && !pend && !emitting;
  assign dec_valid = emitting;
  assign dec_keep  = acc[e_col] >= thr_q;
  assign dec_row   = e_row;
  assign dec_col   = e_col;

  function automatic logic [11:0] sm(input logic [7:0] a, b, c, d, e);
    sm = 12'(a) + 12'(b) * 12'd4 + 12'(c) * 12'd6 + 12'(d) * 12'd4 + 12'(e);
  endfunction

  function automatic logic [13:0] deriv(input logic [11:0] s0, s1, s3, s4);
    logic [13:0] p, n;
    p = 14'(s3) * 14'd2 + 14'(s4);
    n = 14'(s1) * 14'd2 + 14'(s0);
    deriv = p >= n ? p - n : n - p;
  endfunction

  logic [11:0] sv [0:4];
  logic [11:0] hv [0:4];
  logic [14:0] mag;

  always_comb begin
    for (int k = 0; k < 5; k++) begin
      sv[k] = sm(win[0][k], win[1][k], win[2][k], win[3][k], win[4][k]);
      hv[k] = sm(win[k][0], win[k][1], win[k][2], win[k][3], win[k][4]);
    end
    mag = 15'(deriv(sv[0], sv[1], sv[3], sv[4])) + 15'(deriv(hv[0], hv[1], hv[3], hv[4]));
  end

  always_ff @(posedge clk) begin
    if (take) begin
      lb[0][col_q] <= pix_data;
      for (int k = 1; k < 4; k++) lb[k][col_q] <= lb[k-1][col_q];
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 4; j++) win[i][j] <= win[i][j+1];
      win[0][4] <= lb[3][col_q];
      win[1][4] <= lb[2][col_q];
      win[2][4] <= lb[1][col_q];
      win[3][4] <= lb[0][col_q];
      win[4][4] <= pix_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; pend <= 1'b0; emitting <= 1'b0; g_vld <= 1'b0;
      col_q <= '0; row_q <= '0; thr_q <= '0;
      pend_row <= '0; e_row <= '0; e_col <= '0; g_tc <= '0;
      for (int k = 0; k < NTC; k++) acc[k] <= '0;
    end else if (frame_start) begin
      active <= 1'b1; pend <= 1'b0; emitting <= 1'b0; g_vld <= 1'b0;
      col_q <= '0; row_q <= '0; thr_q <= thr_in;
      e_col <= '0;
      for (int k = 0; k < NTC; k++) acc[k] <= '0;
    end else begin
      g_vld <= gv;
      g_tc  <= ctr_tc;
      pend  <= trig;
      if (trig) pend_row <= trig_row;
      if (take) begin
        col_q <= last_col ? '0 : col_q + CW'(1);
        if (last_col) row_q <= row_q + RW'(1);
        if (last_col && last_row) active <= 1'b0;
      end
      if (g_vld) acc[g_tc] <= acc[g_tc] + AW'(mag);
      if (pend) begin
        emitting <= 1'b1;
        e_col    <= '0;
        e_row    <= pend_row;
      end else if (emitting) begin
        acc[e_col] <= '0;
        e_col <= e_col + TCW'(1);
        if (e_col == TCW'(NTC - 1)) emitting <= 1'b0;
      end
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    g_vld |-> ({1'b0, acc[g_tc]} + (AW+1)'(mag)) < (AW+1)'(2**AW));

  a_r1_no_accum_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
    g_vld |-> !emitting);

  a_r7_col_order: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_col != '0) |-> ($past(dec_valid) && dec_col == $past(dec_col) + TCW'(1)));

  a_r7_full_row: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dec_valid) && !$past(frame_start)) |-> $past(dec_col) == TCW'(NTC - 1));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!dec_valid && !pend));

  a_r9_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_col && last_row && !frame_start) |=> !pix_ready);
endmodule

// File: tb/grad_tile_seg_bench.sv
module grad_tile_seg_bench;
  localparam int W = 16, H = 16, NT = 4;

  logic clk = 0, rst_n = 0, frame_start = 0, pix_valid = 0;
  logic [20:0] thr_in = 0;
  logic [7:0] pix_data = 0;
  logic pix_ready, dec_valid, dec_keep;
  logic dec_row, dec_col;

  grad_tile_seg #(.IMG_W(W), .IMG_H(H)) u_grad_tile_seg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .thr_in(thr_in),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .dec_valid(dec_valid), .dec_keep(dec_keep), .dec_row(dec_row), .dec_col(dec_col));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int img [0:H-1][0:W-1];
  int dcount = 0, ready_viol = 0;
  int rec_keep [0:15], rec_row [0:15], rec_col [0:15];
  int kv [0:4] = '{1, 4, 6, 4, 1};
  int kd [0:4] = '{-1, -2, 0, 2, 1};

  always @(negedge clk) begin
    if (dec_valid) begin
      if (dcount < 16) begin
        rec_keep[dcount] = dec_keep; rec_row[dcount] = dec_row; rec_col[dcount] = dec_col;
      end
      dcount++;
      if (pix_ready) ready_viol++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gmag(int y, int x);
    int gx = 0, gy = 0;
    if (y < 2 || y > H-3 || x < 2 || x > W-3) return 0;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++) begin
        gx += kv[i] * kd[j] * img[y-2+i][x-2+j];
        gy += kd[i] * kv[j] * img[y-2+i][x-2+j];
      end
    return (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
  endfunction

  function automatic int tsum(int tr, int tc);
    int s = 0;
    for (int y = tr*8; y < tr*8+8; y++)
      for (int x = tc*8; x < tc*8+8; x++) s += gmag(y, x);
    return s;
  endfunction

  task automatic fill_flat(int v);
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = v;
  endtask

  task automatic fill_noise(int seed0);
    logic [31:0] s = seed0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        s = s * 32'd1103515245 + 32'd12345;
        img[y][x] = int'((s >> 16) & 32'hff) % (16 + 60 * ((y/8)*2 + x/8));
      end
  endtask

  task automatic start_frame(int thr);
    @(negedge clk);
    thr_in = 21'(thr); frame_start = 1; dcount = 0; ready_viol = 0;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic send_pixels(int n, bit gaps);
    int idx = 0, cyc = 0;
    while (idx < n) begin
      @(negedge clk);
      if (gaps && cyc % 3 == 1) pix_valid = 0;
      else begin
        pix_valid = 1;
        pix_data = 8'(img[idx / W][idx % W]);
        if (pix_ready) idx++;
      end
      cyc++;
    end
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic collect(string tag);
    int t = 0;
    while (dcount < NT && t < 400) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    chk(dcount == NT, {tag, " R7 decision count"}, dcount, NT);
    chk(ready_viol == 0, {tag, " R1 ready low while emitting"}, ready_viol, 0);
  endtask

  task automatic check_decisions(string tag, int thr);
    for (int k = 0; k < NT; k++) begin
      int er = k / 2, ec = k % 2;
      int ek = tsum(er, ec) >= thr;
      chk(rec_row[k] == er, {tag, " R7 tile row tag"}, rec_row[k], er);
      chk(rec_col[k] == ec, {tag, " R7 tile col tag"}, rec_col[k], ec);
      chk(rec_keep[k] == ek, {tag, " R5 keep decision"}, rec_keep[k], ek);
    end
  endtask

  task automatic run_frame(string tag, int thr, bit gaps);
    start_frame(thr);
    send_pixels(W*H, gaps);
    collect(tag);
    check_decisions(tag, thr);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(pix_ready == 0, "R9 reset ready", pix_ready, 0);
    chk(dec_valid == 0, "R9 reset valid", dec_valid, 0);
  endtask

  task automatic t_flat;
    fill_flat(100);
    run_frame("flat thr0", 0, 0);
    run_frame("flat thr1", 1, 0);
    chk(rec_keep[0] == 0, "R5 flat below threshold removed", rec_keep[0], 0);
  endtask

  task automatic t_noise;
    int s01;
    fill_noise(7);
    s01 = tsum(0, 1);
    chk(s01 > 0, "R2 R3 noise tile has gradient", s01, 1);
    run_frame("noise eq", s01, 0);
    chk(rec_keep[1] == 1, "R5 metric equal to threshold kept", rec_keep[1], 1);
    run_frame("noise eq+1", s01 + 1, 1);
    chk(rec_keep[1] == 0, "R5 metric below threshold removed", rec_keep[1], 0);
    run_frame("noise mid", tsum(1, 0), 1);
  endtask

  task automatic t_stripes;
    int big;
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++)
      img[y][x] = ((x / 2) % 2 == 1) ? 255 : 0;
    big = tsum(1, 1);
    run_frame("stripes R4 exact", big, 0);
    chk(rec_keep[3] == 1, "R4 large metric equal kept", rec_keep[3], 1);
    run_frame("stripes R4 exact+1", big + 1, 1);
    chk(rec_keep[3] == 0, "R4 large metric plus one removed", rec_keep[3], 0);
  endtask

  task automatic t_thr_change;
    fill_flat(50);
    start_frame(0);
    thr_in = 21'd1000000;
    send_pixels(W*H, 0);
    collect("thr change");
    for (int k = 0; k < NT; k++)
      chk(rec_keep[k] == 1, "R6 threshold change mid frame ignored", rec_keep[k], 1);
  endtask

  task automatic t_abort;
    fill_noise(99);
    start_frame(1);
    send_pixels(W*6, 0);
    fill_flat(10);
    start_frame(1);
    send_pixels(W*H, 1);
    collect("abort");
    for (int k = 0; k < NT; k++)
      chk(rec_keep[k] == 0, "R8 partial frame discarded", rec_keep[k], 0);
  endtask

  task automatic t_closed;
    int rdy = 0, d0 = dcount;
    @(negedge clk);
    pix_valid = 1; pix_data = 8'hff;
    repeat (20) begin @(negedge clk); if (pix_ready) rdy++; end
    pix_valid = 0;
    chk(rdy == 0, "R9 ready low after last pixel", rdy, 0);
    chk(dcount == d0, "R9 no decisions after frame end", dcount, d0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_flat();
    t_noise();
    t_stripes();
    t_thr_change();
    t_abort();
    t_closed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule